// File: doc/BRIEF.md
# SGRAM Command Front End with Clock-Enable Gating

This block sits on the device side of a two-bank synchronous graphics RAM and turns the command pins sampled on each rising clock edge into one-cycle decoded strobes. A fifth function pin (`spec_fn`) is decoded together with the row, column and write command pins. The block latches the bank, row and column address fields, holds the mode register, and tracks whether each bank is open or closed. Commands that do not fit the current bank state are refused and flagged.

The clock-enable input gates everything. When it is sampled low, the command on that edge still executes. From the next edge on, inputs are ignored and every registered output holds. If both banks are closed at that point, the freeze is reported as power-down; otherwise it is reported as clock suspension. The edge on which clock-enable is sampled high again ends the freeze and accepts the command presented with it. The memory array, the data path and burst counting lie outside this block.

Top module: `sgr_cmd_front`

## Requirements
- R1: After reset, all strobes and `illegal_o` are 0, both banks are closed, `mode_vld_o`, `pwr_down_o` and `clk_susp_o` are 0, and the latched fields are 0.
- R2: With `chip_sel_n` high on an accepted edge, no strobe is raised and no state changes, whatever the other pins hold.
- R3: With `chip_sel_n` low and `row_cmd_n`, `col_cmd_n`, `wr_cmd_n` all high, the command is a no-op for either value of `spec_fn`: no strobe and no state change.
- R4: With `spec_fn` low, the pin triple {row_cmd_n, col_cmd_n, wr_cmd_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh and 000 mode set. A legal command raises its strobe for exactly the one cycle after its sampling edge.
- R5: Triple 110, and any triple other than 111 with `spec_fn` high, is unsupported. It raises `illegal_o` for one cycle and has no other effect.
- R6: Address bit 9 selects the bank (0 = first, 1 = second) and is latched into `bank_o` on a legal activate, read, write or precharge. Bits 8..0 are latched into `row_o` on activate, and bits 7..0 into `col_o` on read or write.
- R7: A legal activate opens the selected bank, and a precharge closes it (precharging a closed bank is legal). An activate to an open bank is illegal.
- R8: A read or write to a closed bank raises `illegal_o` and changes no output field.
- R9: A mode set with both banks closed copies all 10 address bits into `mode_o` and sets `mode_vld_o`. With any bank open it is illegal and `mode_o` is unchanged.
- R10: Refresh is legal only with both banks closed. Otherwise it is illegal.
- R11: With clock-enable low at an edge, that edge's command executes. At each following edge where clock-enable is still low, inputs are ignored, no strobe is raised and all fields hold, with `clk_susp_o` high if a bank is open.
- R12: If both banks are closed after the command on the edge where clock-enable is sampled low, `pwr_down_o` is raised instead of `clk_susp_o` and stays high while clock-enable stays low.
- R13: The first edge with clock-enable sampled high after a freeze clears `pwr_down_o` and `clk_susp_o` and executes the command presented on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock-enable: low freezes the block from the next edge |
| chip_sel_n | input | 1 | Chip select, active low |
| row_cmd_n | input | 1 | Row command pin, active low |
| col_cmd_n | input | 1 | Column command pin, active low |
| wr_cmd_n | input | 1 | Write command pin, active low |
| spec_fn | input | 1 | Special-function pin, must be low for standard commands |
| addr_i | input | 10 | Bit 9 bank select, bits 8..0 row / column / mode data |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pre_o | output | 1 | Precharge strobe |
| ref_o | output | 1 | Refresh strobe |
| mrs_o | output | 1 | Mode set strobe |
| illegal_o | output | 1 | Refused or unsupported command |
| bank_o | output | 1 | Latched bank |
| row_o | output | 9 | Latched row |
| col_o | output | 8 | Latched column |
| mode_o | output | 10 | Mode register |
| mode_vld_o | output | 1 | Mode register has been written |
| bank_active_o | output | 2 | Open flag per bank |
| pwr_down_o | output | 1 | Power-down in effect |
| clk_susp_o | output | 1 | Clock suspension in effect |

## Verification
Two functions can fall on the same edge. A command that changes bank state can arrive on the edge where clock-enable drops, and the freeze type must then follow the bank state after that command. A command can also arrive on the edge where clock-enable returns, and it must execute on that edge. The bench provokes the first case by issuing a precharge of the last open bank, and an activate into two closed banks, together with clock-enable going low. It provokes the second by presenting commands on exit edges. Random runs repeat both cases often. The result is judged by comparing the power-down and suspension flags, the bank flags and the strobes against the bench's own model at every edge.

// File: rtl/sgr_cmd_pkg.sv
package sgr_cmd_pkg;

    typedef enum logic [3:0] {
        OP_DESEL,
        OP_NOP,
        OP_ACT,
        OP_RD,
        OP_WR,
        OP_PRE,
        OP_REF,
        OP_MRS,
        OP_BAD
    } op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic fn;
    } pins_t;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic refr;
        logic mrs;
        logic bad;
    } strobe_t;

    // Pin pattern to operation; fn must be low for every standard command.
    function automatic op_e classify(pins_t p);
        op_e op;
        if (p.cs_n) begin
            op = OP_DESEL;
        end else if ({p.ras_n, p.cas_n, p.we_n} == 3'b111) begin
            op = OP_NOP;
        end else if (p.fn) begin
            op = OP_BAD;
        end else begin
            unique case ({p.ras_n, p.cas_n, p.we_n})
                3'b011:  op = OP_ACT;
                3'b101:  op = OP_RD;
                3'b100:  op = OP_WR;
                3'b010:  op = OP_PRE;
                3'b001:  op = OP_REF;
                3'b000:  op = OP_MRS;
                default: op = OP_BAD;
            endcase
        end
        return op;
    endfunction

    function automatic strobe_t op_to_strobe(op_e op);
        strobe_t s;
        s      = '0;
        s.act  = (op == OP_ACT);
        s.rd   = (op == OP_RD);
        s.wr   = (op == OP_WR);
        s.pre  = (op == OP_PRE);
        s.refr = (op == OP_REF);
        s.mrs  = (op == OP_MRS);
        return s;
    endfunction

    function automatic logic is_command(op_e op);
        return (op != OP_DESEL) && (op != OP_NOP);
    endfunction

endpackage

// File: rtl/sgr_cmd_dec.sv
module sgr_cmd_dec
    import sgr_cmd_pkg::*;
(
    input  pins_t pins_i,
    output op_e   op_o
);
    always_comb begin
        op_o = classify(pins_i);
    end
endmodule

// File: rtl/sgr_cke_ctl.sv
module sgr_cke_ctl (
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  logic idle_after_i,
    output logic accept_o,
    output logic pdn_o,
    output logic susp_o
);
    logic frozen_q;
    logic pdn_q;

    // An edge is accepted unless clock-enable was low on the previous edge
    // and is still low now; a high sample ends any freeze on that edge.
    always_comb begin
        accept_o = !frozen_q || clk_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen_q <= 1'b0;
            pdn_q    <= 1'b0;
        end else begin
            frozen_q <= !clk_en;
            if (clk_en) begin
                pdn_q <= 1'b0;
            end else if (accept_o) begin
                pdn_q <= idle_after_i;
            end
        end
    end

    always_comb begin
        pdn_o  = pdn_q;
        susp_o = frozen_q && !pdn_q;
    end
endmodule

// File: rtl/sgr_bank_track.sv
module sgr_bank_track #(
    parameter int BANK_W = 1,
    localparam int NBANK = 2 ** BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_i,
    input  logic              close_i,
    input  logic [BANK_W-1:0] sel_i,
    output logic [NBANK-1:0]  active_q_o,
    output logic [NBANK-1:0]  active_d_o
);
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic hit;
        logic state_q;

        always_comb begin
            hit = (sel_i == BANK_W'(g));
            if (hit && open_i) begin
                active_d_o[g] = 1'b1;
            end else if (hit && close_i) begin
                active_d_o[g] = 1'b0;
            end else begin
                active_d_o[g] = state_q;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                state_q <= 1'b0;
            end else begin
                state_q <= active_d_o[g];
            end
        end

        always_comb begin
            active_q_o[g] = state_q;
        end
    end
endmodule

// File: rtl/sgr_cmd_front.sv
module sgr_cmd_front
    import sgr_cmd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int ROW_W  = 9,
    parameter int COL_W  = 8,
    localparam int BANK_W = ADDR_W - ROW_W,
    localparam int NBANK  = 2 ** BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              chip_sel_n,
    input  logic              row_cmd_n,
    input  logic              col_cmd_n,
    input  logic              wr_cmd_n,
    input  logic              spec_fn,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              act_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              pre_o,
    output logic              ref_o,
    output logic              mrs_o,
    output logic              illegal_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic [ADDR_W-1:0] mode_o,
    output logic              mode_vld_o,
    output logic [NBANK-1:0]  bank_active_o,
    output logic              pwr_down_o,
    output logic              clk_susp_o
);
    pins_t             pins;
    op_e               op;
    logic              accept;
    logic [BANK_W-1:0] sel;
    logic [NBANK-1:0]  act_q;
    logic [NBANK-1:0]  act_d;
    logic              sel_open;
    logic              all_closed;
    logic              allowed;
    logic              issue;
    logic              legal;
    strobe_t           stb_d;
    strobe_t           stb_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [ADDR_W-1:0] mode_q;
    logic              vld_q;

    always_comb begin
        pins = '{cs_n: chip_sel_n, ras_n: row_cmd_n, cas_n: col_cmd_n,
                 we_n: wr_cmd_n, fn: spec_fn};
        sel  = addr_i[ADDR_W-1 -: BANK_W];
    end

    sgr_cmd_dec u_dec (
        .pins_i (pins),
        .op_o   (op)
    );

    // State checks against the banks as they stand before this edge.
    always_comb begin
        sel_open   = act_q[sel];
        all_closed = (act_q == '0);
        unique case (op)
            OP_ACT:         allowed = !sel_open;
            OP_RD, OP_WR:   allowed = sel_open;
            OP_PRE:         allowed = 1'b1;
            OP_REF, OP_MRS: allowed = all_closed;
            default:        allowed = 1'b0;
        endcase
        issue = accept && is_command(op);
        legal = issue && allowed;
        stb_d = legal ? op_to_strobe(op) : '0;
        stb_d.bad = issue && !allowed;
    end

    sgr_bank_track #(.BANK_W(BANK_W)) u_banks (
        .clk        (clk),
        .rst        (rst),
        .open_i     (stb_d.act),
        .close_i    (stb_d.pre),
        .sel_i      (sel),
        .active_q_o (act_q),
        .active_d_o (act_d)
    );

    sgr_cke_ctl u_cke (
        .clk          (clk),
        .rst          (rst),
        .clk_en       (clk_en),
        .idle_after_i (act_d == '0),
        .accept_o     (accept),
        .pdn_o        (pwr_down_o),
        .susp_o       (clk_susp_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= '0;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            mode_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            stb_q <= stb_d;
            if (stb_d.act || stb_d.rd || stb_d.wr || stb_d.pre) begin
                bank_q <= sel;
            end
            if (stb_d.act) begin
                row_q <= addr_i[ROW_W-1:0];
            end
            if (stb_d.rd || stb_d.wr) begin
                col_q <= addr_i[COL_W-1:0];
            end
            if (stb_d.mrs) begin
                mode_q <= addr_i;
                vld_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        act_o         = stb_q.act;
        rd_o          = stb_q.rd;
        wr_o          = stb_q.wr;
        pre_o         = stb_q.pre;
        ref_o         = stb_q.refr;
        mrs_o         = stb_q.mrs;
        illegal_o     = stb_q.bad;
        bank_o        = bank_q;
        row_o         = row_q;
        col_o         = col_q;
        mode_o        = mode_q;
        mode_vld_o    = vld_q;
        bank_active_o = act_q;
    end
endmodule

// File: rtl/sgr_cmd_chk.sv
module sgr_cmd_chk #(
    parameter int ADDR_W = 10,
    parameter int ROW_W  = 9,
    parameter int COL_W  = 8,
    localparam int BANK_W = ADDR_W - ROW_W,
    localparam int NBANK  = 2 ** BANK_W
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en,
    input logic              act_o,
    input logic              rd_o,
    input logic              wr_o,
    input logic              pre_o,
    input logic              ref_o,
    input logic              mrs_o,
    input logic              illegal_o,
    input logic [BANK_W-1:0] bank_o,
    input logic [ROW_W-1:0]  row_o,
    input logic [COL_W-1:0]  col_o,
    input logic [ADDR_W-1:0] mode_o,
    input logic              mode_vld_o,
    input logic [NBANK-1:0]  bank_active_o,
    input logic              pwr_down_o,
    input logic              clk_susp_o
);
    logic en_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev <= 1'b1;
        end else begin
            en_prev <= clk_en;
        end
    end

    // R4
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o}));

    // R7
    act_opens_chk: assert property (@(posedge clk) disable iff (rst)
        act_o |-> bank_active_o[bank_o]);

    // R7
    pre_closes_chk: assert property (@(posedge clk) disable iff (rst)
        pre_o |-> !bank_active_o[bank_o]);

    // R8
    access_open_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_o || wr_o) |-> bank_active_o[bank_o]);

    // R9
    mode_change_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o != $past(mode_o)) |-> mrs_o);

    // R9
    mode_idle_chk: assert property (@(posedge clk) disable iff (rst)
        mrs_o |-> (bank_active_o == '0 && mode_vld_o));

    // R10
    refresh_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ref_o |-> (bank_active_o == '0));

    // R12
    pdn_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down_o |-> (bank_active_o == '0 && !clk_susp_o));

    // R11
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_prev && !clk_en) |=>
            (!act_o && !rd_o && !wr_o && !pre_o && !ref_o && !mrs_o && !illegal_o
             && $stable(bank_o) && $stable(row_o) && $stable(col_o)
             && $stable(mode_o) && $stable(bank_active_o)));

    // R13
    wake_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> (!pwr_down_o && !clk_susp_o));
endmodule

bind sgr_cmd_front sgr_cmd_chk #(
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .clk_en        (clk_en),
    .act_o         (act_o),
    .rd_o          (rd_o),
    .wr_o          (wr_o),
    .pre_o         (pre_o),
    .ref_o         (ref_o),
    .mrs_o         (mrs_o),
    .illegal_o     (illegal_o),
    .bank_o        (bank_o),
    .row_o         (row_o),
    .col_o         (col_o),
    .mode_o        (mode_o),
    .mode_vld_o    (mode_vld_o),
    .bank_active_o (bank_active_o),
    .pwr_down_o    (pwr_down_o),
    .clk_susp_o    (clk_susp_o)
);

// File: tb/sgr_cmd_front_tb.sv
`timescale 1ns/1ps
module sgr_cmd_front_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b1;
    logic       chip_sel_n = 1'b1;
    logic       row_cmd_n = 1'b1;
    logic       col_cmd_n = 1'b1;
    logic       wr_cmd_n = 1'b1;
    logic       spec_fn = 1'b0;
    logic [9:0] addr_i = '0;
    logic act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o;
    logic [0:0] bank_o;
    logic [8:0] row_o;
    logic [7:0] col_o;
    logic [9:0] mode_o;
    logic       mode_vld_o;
    logic [1:0] bank_active_o;
    logic       pwr_down_o, clk_susp_o;

    always #4 clk = ~clk;

    sgr_cmd_front u_dut (
        .clk (clk), .rst (rst), .clk_en (clk_en), .chip_sel_n (chip_sel_n),
        .row_cmd_n (row_cmd_n), .col_cmd_n (col_cmd_n), .wr_cmd_n (wr_cmd_n),
        .spec_fn (spec_fn), .addr_i (addr_i),
        .act_o (act_o), .rd_o (rd_o), .wr_o (wr_o), .pre_o (pre_o),
        .ref_o (ref_o), .mrs_o (mrs_o), .illegal_o (illegal_o),
        .bank_o (bank_o), .row_o (row_o), .col_o (col_o), .mode_o (mode_o),
        .mode_vld_o (mode_vld_o), .bank_active_o (bank_active_o),
        .pwr_down_o (pwr_down_o), .clk_susp_o (clk_susp_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // Bench model state, built from the requirements.
    bit       m_frozen = 0, m_pdn = 0, m_vld = 0;
    bit [1:0] m_act = '0;
    bit       m_bank = 0;
    bit [8:0] m_row = '0;
    bit [7:0] m_col = '0;
    bit [9:0] m_mode = '0;
    bit [6:0] e_stb = '0;   // {act, rd, wr, pre, ref, mrs, illegal}
    string    e_tag = "R1";

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic model(bit ck, bit cs, bit r, bit c, bit w, bit d, bit [9:0] a);
        bit acc;
        bit b;
        acc = !m_frozen || ck;
        b = a[9];
        e_stb = '0;
        if (!acc) begin
            e_tag = m_pdn ? "R12" : "R11";
        end else begin
            if (cs) e_tag = "R2";
            else if ({r, c, w} == 3'b111) e_tag = "R3";
            else if (d || {r, c, w} == 3'b110) begin
                e_tag = "R5"; e_stb = 7'b0000001;
            end else begin
                case ({r, c, w})
                    3'b011: begin
                        e_tag = "R7";
                        if (m_act[b]) e_stb = 7'b0000001;
                        else begin
                            e_stb = 7'b1000000; m_act[b] = 1; m_bank = b; m_row = a[8:0];
                        end
                    end
                    3'b101, 3'b100: begin
                        if (!m_act[b]) begin e_tag = "R8"; e_stb = 7'b0000001; end
                        else begin
                            e_tag = "R4";
                            e_stb = ({r, c, w} == 3'b101) ? 7'b0100000 : 7'b0010000;
                            m_bank = b; m_col = a[7:0];
                        end
                    end
                    3'b010: begin
                        e_tag = "R7"; e_stb = 7'b0001000; m_act[b] = 0; m_bank = b;
                    end
                    3'b001: begin
                        e_tag = "R10";
                        e_stb = (m_act == 0) ? 7'b0000100 : 7'b0000001;
                    end
                    default: begin
                        e_tag = "R9";
                        if (m_act == 0) begin e_stb = 7'b0000010; m_mode = a; m_vld = 1; end
                        else e_stb = 7'b0000001;
                    end
                endcase
            end
            if (m_frozen) e_tag = "R13";
        end
        m_pdn = !ck && (acc ? (m_act == 0) : m_pdn);
        m_frozen = !ck;
    endtask

    task automatic compare_all();
        chk(e_tag, "strobes", {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o}, e_stb);
        chk("R6", "bank", bank_o, m_bank);
        chk("R6", "row", row_o, m_row);
        chk("R6", "col", col_o, m_col);
        chk("R7", "bank_active", bank_active_o, m_act);
        chk("R9", "mode", {mode_vld_o, mode_o}, {m_vld, m_mode});
        chk("R12", "pwr_down", pwr_down_o, m_pdn);
        chk("R11", "clk_susp", clk_susp_o, m_frozen && !m_pdn);
    endtask

    task automatic step(bit ck, bit cs, bit [2:0] rcw, bit d, bit [9:0] a);
        @(negedge clk);
        clk_en = ck; chip_sel_n = cs;
        {row_cmd_n, col_cmd_n, wr_cmd_n} = rcw;
        spec_fn = d; addr_i = a;
        model(ck, cs, rcw[2], rcw[1], rcw[0], d, a);
        @(posedge clk);
        #1;
        compare_all();
    endtask

    localparam bit [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000, C_STOP = 3'b110;

    initial begin
        #1_000_000;
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "strobes", {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o}, 0);
        chk("R1", "bank_active", bank_active_o, 0);
        chk("R1", "flags", {mode_vld_o, pwr_down_o, clk_susp_o}, 0);
        chk("R1", "fields", {bank_o, row_o, col_o, mode_o}, 0);

        step(1, 0, C_MRS, 0, 10'h2A5);   // R9 mode set while closed
        step(1, 1, C_MRS, 0, 10'h3FF);   // R2 deselected, mode held
        step(1, 0, C_NOP, 1, 10'h155);   // R3 no-op with fn high
        step(1, 0, C_RD,  0, 10'h012);   // R8 read of closed bank
        step(1, 0, C_ACT, 0, 10'h3AB);   // R6 R7 open second bank
        step(1, 0, C_ACT, 0, 10'h201);   // R7 reopen is illegal
        step(1, 0, C_MRS, 0, 10'h000);   // R9 refused with open bank
        step(1, 0, C_REF, 0, 10'h000);   // R10 refused with open bank
        step(1, 0, C_WR,  0, 10'h25C);   // R4 R6 write column
        step(1, 0, C_WR,  1, 10'h233);   // R5 fn high
        step(1, 0, C_STOP, 0, 10'h000);  // R5 unsupported triple
        step(0, 0, C_RD,  0, 10'h271);   // R11 read executes on low edge
        step(0, 0, C_ACT, 0, 10'h0AA);   // R11 ignored
        step(0, 0, C_PRE, 0, 10'h200);   // R11 ignored
        step(1, 0, C_RD,  0, 10'h244);   // R13 wake with read
        step(0, 0, C_PRE, 0, 10'h200);   // R12 last bank closed on low edge
        step(0, 0, C_ACT, 0, 10'h011);   // R12 ignored
        step(1, 0, C_ACT, 0, 10'h0F0);   // R13 wake with activate
        step(1, 0, C_PRE, 0, 10'h000);
        step(1, 0, C_REF, 0, 10'h000);   // R10 refresh while closed
        step(0, 0, C_ACT, 0, 10'h123);   // R11 activate on low edge: suspension
        step(1, 0, C_PRE, 0, 10'h123);

        for (int i = 0; i < 4000; i++) begin
            bit [2:0] rcw;
            case ($urandom % 9)
                0: rcw = C_NOP;  1, 2: rcw = C_ACT;  3: rcw = C_RD;  4: rcw = C_WR;
                5, 6: rcw = C_PRE;  7: rcw = ($urandom % 2) ? C_REF : C_MRS;
                default: rcw = C_STOP;
            endcase
            step(($urandom % 5) != 0, ($urandom % 10) == 0, rcw,
                 ($urandom % 8) == 0, 10'($urandom));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule